// File: doc/BRIEF.md
# Packed BCD Byte Arithmetic Unit

This unit performs decimal arithmetic on one byte that holds two packed decimal digits. It supports three operations. Add-with-extend sums two operands and the incoming extend bit. Subtract-with-extend takes the source and the extend bit away from the destination. Negate-with-extend takes the source and the extend bit away from zero. Each raw result is corrected back into two valid decimal digits. The unit also produces updated extend, carry and zero flags.

Numbers wider than one byte are processed one byte at a time, starting with the least significant byte. The caller feeds the extend output of one byte into the extend input of the next. The caller also feeds the zero output back into the zero input. The zero flag can only be cleared by these operations, never set. It therefore ends up reporting whether the whole multi-byte result is zero, provided the caller sets it to one before the first byte.

A one-cycle `valid_in` strobe captures the operation. The result and flags appear on registered outputs at the next clock edge, together with a one-cycle `done_out` pulse. Both operands are assumed to hold valid decimal digits.

Top module: `bcd_byte_unit`

## Requirements
- R1: With `op_in` = 2'b00, the result is (D + S + X) mod 100 in packed BCD, where D is the destination, S the source and X the extend input, each taken as a decimal value. Carry is 1 exactly when D + S + X exceeds 99.
- R2: With `op_in` = 2'b01, the result is (D − S − X) mod 100 in packed BCD. Carry (borrow) is 1 exactly when D < S, or when X = 1 and D = S.
- R3: With `op_in` = 2'b10, the result is (0 − S − X) mod 100 in packed BCD, and `dst_in` has no effect. Carry is 1 exactly when S is nonzero or X = 1.
- R4: After every operation, the extend output equals the carry output.
- R5: The zero output is 0 when the result byte is nonzero. When the result byte is zero, the zero output equals `z_in`, so it is never set to 1 by an operation.
- R6: Result and flags appear one clock edge after the edge that samples `valid_in` = 1. `done_out` is 1 for exactly that one cycle.
- R7: While `valid_in` is 0, the result and flag outputs keep their values and `done_out` is 0.
- R8: A synchronous active-high `rst` clears the result, all flags and `done_out` to 0 at the next clock edge.
- R9: Given valid BCD operands, both nibbles of the result are at most 9.
- R10: `op_in` = 2'b11 behaves exactly like the add operation of R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | One-cycle strobe that starts an operation |
| op_in | input | 2 | Operation: 00 add, 01 subtract, 10 negate, 11 add |
| dst_in | input | 8 | Destination operand in packed BCD |
| src_in | input | 8 | Source operand in packed BCD; this is the operand negated by op 10 |
| x_in | input | 1 | Incoming extend bit |
| z_in | input | 1 | Incoming zero flag |
| done_out | output | 1 | One-cycle pulse marking fresh outputs |
| res_out | output | 8 | Corrected packed BCD result |
| x_out | output | 1 | Updated extend flag |
| z_out | output | 1 | Updated zero flag |
| c_out | output | 1 | Carry or borrow flag |

## Verification
Every result and flag is due exactly one clock edge after the edge at which `valid_in` is sampled high. The bench drives inputs on the falling edge. It removes the strobe on the next falling edge and samples the outputs at that point, which falls between the registering edge and the following one. One further falling edge is used to confirm that `done_out` has dropped and that the outputs hold (R7). Reset is likewise checked on the falling edge that follows the reset edge. Chained two-byte operations take each byte's extend and zero outputs from the previous sample and feed them in as the next byte's inputs.

// File: rtl/bcd_unit_pkg.sv
package bcd_unit_pkg;

    localparam int DIG_W   = 4;
    localparam int NUM_DIG = 2;
    localparam int BYTE_W  = DIG_W * NUM_DIG;
    localparam int DIG_MAX = 9;

    typedef enum logic [1:0] {
        BOP_ADD     = 2'b00,
        BOP_SUB     = 2'b01,
        BOP_NEG     = 2'b10,
        BOP_ADD_ALT = 2'b11
    } bop_e;

    typedef struct packed {
        logic [BYTE_W-1:0] value;
        logic              carry;
        logic              ext;
        logic              zero;
    } bcd_res_t;

    function automatic logic byte_is_zero(input logic [BYTE_W-1:0] b);
        return (b == '0);
    endfunction

    function automatic logic op_is_sub_like(input bop_e op);
        return (op == BOP_SUB) || (op == BOP_NEG);
    endfunction

endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int WIDE = W + 1;
    logic [WIDE-1:0] raw;
    logic            fix;

    always_comb begin
        raw  = WIDE'(a) + WIDE'(b) + WIDE'(cin);
        fix  = (raw > WIDE'(9));
        sum  = fix ? (raw[W-1:0] + W'(6)) : raw[W-1:0];
        cout = fix;
    end
endmodule

// File: rtl/bcd_digit_sub.sv
module bcd_digit_sub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         bin,
    output logic [W-1:0] diff,
    output logic         bout
);
    localparam int WIDE = W + 1;
    logic [WIDE-1:0] raw;
    logic            brw;

    always_comb begin
        raw  = WIDE'(a) - WIDE'(b) - WIDE'(bin);
        brw  = raw[W];
        diff = brw ? (raw[W-1:0] - W'(6)) : raw[W-1:0];
        bout = brw;
    end
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain
    import bcd_unit_pkg::*;
#(
    parameter bit SUBTRACT = 1'b0
) (
    input  logic [BYTE_W-1:0] lhs,
    input  logic [BYTE_W-1:0] rhs,
    input  logic              c_first,
    output logic [BYTE_W-1:0] result,
    output logic              c_last
);
    logic [NUM_DIG:0] link;

    assign link[0] = c_first;

    for (genvar d = 0; d < NUM_DIG; d++) begin : g_digit
        if (SUBTRACT) begin : g_sub
            bcd_digit_sub #(.W(DIG_W)) u_sub (
                .a    (lhs[d*DIG_W +: DIG_W]),
                .b    (rhs[d*DIG_W +: DIG_W]),
                .bin  (link[d]),
                .diff (result[d*DIG_W +: DIG_W]),
                .bout (link[d+1])
            );
        end else begin : g_add
            bcd_digit_add #(.W(DIG_W)) u_add (
                .a    (lhs[d*DIG_W +: DIG_W]),
                .b    (rhs[d*DIG_W +: DIG_W]),
                .cin  (link[d]),
                .sum  (result[d*DIG_W +: DIG_W]),
                .cout (link[d+1])
            );
        end
    end

    assign c_last = link[NUM_DIG];
endmodule

// File: rtl/bcd_byte_alu.sv
module bcd_byte_alu
    import bcd_unit_pkg::*;
(
    input  bop_e              op,
    input  logic [BYTE_W-1:0] dst,
    input  logic [BYTE_W-1:0] src,
    input  logic              x_prev,
    input  logic              z_prev,
    output bcd_res_t          res
);
    logic [BYTE_W-1:0] add_val;
    logic              add_c;
    logic [BYTE_W-1:0] sub_val;
    logic              sub_c;
    logic [BYTE_W-1:0] minuend;

    assign minuend = (op == BOP_NEG) ? '0 : dst;

    bcd_digit_chain #(.SUBTRACT(1'b0)) u_add_chain (
        .lhs     (dst),
        .rhs     (src),
        .c_first (x_prev),
        .result  (add_val),
        .c_last  (add_c)
    );

    bcd_digit_chain #(.SUBTRACT(1'b1)) u_sub_chain (
        .lhs     (minuend),
        .rhs     (src),
        .c_first (x_prev),
        .result  (sub_val),
        .c_last  (sub_c)
    );

    always_comb begin
        if (op_is_sub_like(op)) begin
            res.value = sub_val;
            res.carry = sub_c;
        end else begin
            res.value = add_val;
            res.carry = add_c;
        end
        res.ext  = res.carry;
        res.zero = byte_is_zero(res.value) ? z_prev : 1'b0;
    end
endmodule

// File: rtl/bcd_byte_unit.sv
module bcd_byte_unit
    import bcd_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [1:0]        op_in,
    input  logic [BYTE_W-1:0] dst_in,
    input  logic [BYTE_W-1:0] src_in,
    input  logic              x_in,
    input  logic              z_in,
    output logic              done_out,
    output logic [BYTE_W-1:0] res_out,
    output logic              x_out,
    output logic              z_out,
    output logic              c_out
);
    bcd_res_t next_res;
    bcd_res_t held_res;
    logic     done_q;

    bcd_byte_alu u_alu (
        .op     (bop_e'(op_in)),
        .dst    (dst_in),
        .src    (src_in),
        .x_prev (x_in),
        .z_prev (z_in),
        .res    (next_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held_res <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= valid_in;
            if (valid_in) begin
                held_res <= next_res;
            end
        end
    end

    assign done_out = done_q;
    assign res_out  = held_res.value;
    assign x_out    = held_res.ext;
    assign z_out    = held_res.zero;
    assign c_out    = held_res.carry;
endmodule

// File: rtl/bcd_byte_unit_chk.sv
module bcd_byte_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       valid_in,
    input logic [1:0] op_in,
    input logic [7:0] src_in,
    input logic       x_in,
    input logic       z_in,
    input logic       done_out,
    input logic [7:0] res_out,
    input logic       x_out,
    input logic       z_out,
    input logic       c_out
);
    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> done_out); // R6
    AST_DONE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> !done_out); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ($stable(res_out) && $stable(x_out) && $stable(z_out) && $stable(c_out))); // R7
    AST_Z_CLEAR_NONZERO: assert property (@(posedge clk) disable iff (rst)
        (done_out && res_out != 8'h00) |-> !z_out); // R5
    AST_Z_NEVER_SET: assert property (@(posedge clk) disable iff (rst)
        valid_in && !z_in |=> !z_out); // R5
    AST_X_TRACKS_C: assert property (@(posedge clk) disable iff (rst)
        done_out |-> (x_out == c_out)); // R4
    AST_BCD_DIGITS: assert property (@(posedge clk) disable iff (rst)
        done_out |-> (res_out[3:0] <= 4'd9 && res_out[7:4] <= 4'd9)); // R9
    AST_NEG_ZERO_QUIET: assert property (@(posedge clk) disable iff (rst)
        (valid_in && op_in == 2'b10 && src_in == 8'h00 && !x_in) |=> (!c_out && res_out == 8'h00)); // R3
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!done_out && res_out == 8'h00 && !c_out && !z_out && !x_out)); // R8
endmodule

bind bcd_byte_unit bcd_byte_unit_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .valid_in (valid_in),
    .op_in    (op_in),
    .src_in   (src_in),
    .x_in     (x_in),
    .z_in     (z_in),
    .done_out (done_out),
    .res_out  (res_out),
    .x_out    (x_out),
    .z_out    (z_out),
    .c_out    (c_out)
);

// File: tb/bcd_byte_unit_tb.sv
module bcd_byte_unit_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       valid_in = 1'b0;
    logic [1:0] op_in = 2'b00;
    logic [7:0] dst_in = 8'h00;
    logic [7:0] src_in = 8'h00;
    logic       x_in = 1'b0;
    logic       z_in = 1'b0;
    logic       done_out;
    logic [7:0] res_out;
    logic       x_out, z_out, c_out;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    bcd_byte_unit u_dut (
        .clk(clk), .rst(rst), .valid_in(valid_in), .op_in(op_in),
        .dst_in(dst_in), .src_in(src_in), .x_in(x_in), .z_in(z_in),
        .done_out(done_out), .res_out(res_out), .x_out(x_out),
        .z_out(z_out), .c_out(c_out)
    );

    // {op, dst, src, x, z, exp_res, exp_c, exp_z}
    localparam int NVEC = 15;
    localparam logic [29:0] VEC [NVEC] = '{
        {2'd0, 8'h45, 8'h38, 1'b0, 1'b1, 8'h83, 1'b0, 1'b0},  // R1
        {2'd0, 8'h99, 8'h01, 1'b0, 1'b1, 8'h00, 1'b1, 1'b1},  // R1 R5
        {2'd0, 8'h99, 8'h99, 1'b1, 1'b0, 8'h99, 1'b1, 1'b0},  // R1
        {2'd0, 8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},  // R1 R5
        {2'd1, 8'h50, 8'h25, 1'b0, 1'b1, 8'h25, 1'b0, 1'b0},  // R2
        {2'd1, 8'h25, 8'h50, 1'b0, 1'b1, 8'h75, 1'b1, 1'b0},  // R2
        {2'd1, 8'h42, 8'h42, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0},  // R2
        {2'd1, 8'h42, 8'h42, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},  // R2 R5
        {2'd1, 8'h42, 8'h42, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0},  // R5
        {2'd2, 8'h77, 8'h01, 1'b0, 1'b1, 8'h99, 1'b1, 1'b0},  // R3
        {2'd2, 8'h55, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},  // R3
        {2'd2, 8'h55, 8'h00, 1'b1, 1'b1, 8'h99, 1'b1, 1'b0},  // R3
        {2'd2, 8'h12, 8'h37, 1'b1, 1'b0, 8'h62, 1'b1, 1'b0},  // R3
        {2'd3, 8'h15, 8'h27, 1'b1, 1'b1, 8'h43, 1'b0, 1'b0},  // R10
        {2'd1, 8'h10, 8'h01, 1'b0, 1'b0, 8'h09, 1'b0, 1'b0}   // R2
    };

    task automatic check(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic int to_dec(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] to_bcd(input int n);
        return {4'(n / 10), 4'(n % 10)};
    endfunction

    task automatic model(input logic [1:0] op, input logic [7:0] d, input logic [7:0] s,
                         input logic x, output logic [7:0] r, output logic c);
        int n;
        case (op)
            2'd1:    n = to_dec(d) - to_dec(s) - int'(x);
            2'd2:    n = 0 - to_dec(s) - int'(x);
            default: n = to_dec(d) + to_dec(s) + int'(x);
        endcase
        if (op == 2'd1 || op == 2'd2) begin
            c = (n < 0);
            if (n < 0) n = n + 100;
        end else begin
            c = (n > 99);
            n = n % 100;
        end
        r = to_bcd(n);
    endtask

    task automatic run_op(input logic [1:0] op, input logic [7:0] d, input logic [7:0] s,
                          input logic x, input logic z);
        @(negedge clk);
        op_in = op; dst_in = d; src_in = s; x_in = x; z_in = z; valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset res", int'(res_out), 0);
        check("R8 reset flags", int'({done_out, x_out, z_out, c_out}), 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [29:0] v;
            v = VEC[i];
            run_op(v[29:28], v[27:20], v[19:12], v[11], v[10]);
            check($sformatf("R1/R2/R3/R10 vec%0d res", i), int'(res_out), int'(v[9:2]));
            check($sformatf("R1/R2/R3/R10 vec%0d carry", i), int'(c_out), int'(v[1]));
            check($sformatf("R5 vec%0d zero", i), int'(z_out), int'(v[0]));
            check($sformatf("R4 vec%0d ext", i), int'(x_out), int'(v[1]));
            check($sformatf("R6 vec%0d done", i), int'(done_out), 1);
        end

        // R6 / R7: done drops, outputs hold while idle; inputs wiggle without strobe
        run_op(2'd0, 8'h58, 8'h27, 1'b0, 1'b1);  // 85
        dst_in = 8'h11; src_in = 8'h22; x_in = 1'b1; op_in = 2'd1;
        @(negedge clk);
        check("R6 done single cycle", int'(done_out), 0);
        repeat (3) @(negedge clk);
        check("R7 hold res", int'(res_out), 8'h85);
        check("R7 hold flags", int'({x_out, z_out, c_out}), 0);

        // R3: dst has no effect on negate
        run_op(2'd2, 8'h00, 8'h45, 1'b0, 1'b1);
        check("R3 neg dst=00", int'(res_out), 8'h55);
        run_op(2'd2, 8'h99, 8'h45, 1'b0, 1'b1);
        check("R3 neg dst=99", int'(res_out), 8'h55);

        // model sweep R1 R2 R3
        for (int op = 0; op < 3; op++) begin
            for (int a = 0; a < 100; a += 13) begin
                for (int xb = 0; xb < 2; xb++) begin
                    logic [7:0] er; logic ec;
                    model(2'(op), to_bcd(a), to_bcd(99 - a / 2), 1'(xb), er, ec);
                    run_op(2'(op), to_bcd(a), to_bcd(99 - a / 2), 1'(xb), 1'b1);
                    check("R1/R2/R3 sweep res", int'(res_out), int'(er));
                    check("R1/R2/R3 sweep carry", int'(c_out), int'(ec));
                end
            end
        end

        // R5 chained two-byte operations, low byte first
        begin
            int ca [6] = '{1234, 0, 5000, 100, 0, 4321};
            int cb [6] = '{8766, 0, 5000, 0, 1, 4320};
            logic [1:0] co [6] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd2, 2'd1};
            for (int k = 0; k < 6; k++) begin
                logic [7:0] lo_r, hi_r; logic lo_c, hi_c, zc;
                model(co[k], to_bcd(ca[k] % 100), to_bcd(cb[k] % 100), 1'b0, lo_r, lo_c);
                model(co[k], to_bcd(ca[k] / 100), to_bcd(cb[k] / 100), lo_c, hi_r, hi_c);
                run_op(co[k], to_bcd(ca[k] % 100), to_bcd(cb[k] % 100), 1'b0, 1'b1);
                check("R1/R2/R3 chain low", int'(res_out), int'(lo_r));
                run_op(co[k], to_bcd(ca[k] / 100), to_bcd(cb[k] / 100), x_out, z_out);
                check("R1/R2/R3 chain high", int'(res_out), int'(hi_r));
                check("R4 chain carry", int'(x_out), int'(hi_c));
                zc = (lo_r == 8'h00) && (hi_r == 8'h00);
                check($sformatf("R5 chain%0d sticky zero", k), int'(z_out), int'(zc));
            end
        end

        // R8: reset after activity
        run_op(2'd2, 8'h00, 8'h01, 1'b1, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset after op res", int'(res_out), 0);
        check("R8 reset after op flags", int'({done_out, x_out, z_out, c_out}), 0);
        rst = 1'b0;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule